// File: doc/BRIEF.md
# Periodic Countdown Timer with Watchdog Escalation

This block is a register-programmed down-counter advanced by an external 1 MHz tick enable. Software writes a control word with an enable bit, a mode bit and a reload value. Each enabled tick lowers the live count by one. The count is "terminal" when it is zero and a tick arrives. On a terminal count the block raises an interrupt. In periodic mode it then reloads the programmed value, and in one-shot mode it halts and drops its own enable.

Interrupt service takes two steps. The handler writes the clear bit in the status register, which arms the acknowledge. A later read of the control register then completes it. The watchdog output does not react to the first unserviced expiry. It pulses when a terminal count arrives while the interrupt from the previous expiry is still pending. A desired timeout therefore needs half the raw count: load = T·f/2 − 1. After the pulse the watchdog stays tripped and silent until software disables the timer.

Top module: `periodic_wdog_timer`

## Requirements
- R1: After reset, both registers read zero, `irq_o` is low and `wdog_rst_o` is low.
- R2: While enabled, the live count falls by exactly one on each cycle with `tick_i` high and nonzero count. With `tick_i` low it holds.
- R3: With load value L, the pending flag sets on the (L+1)-th tick after the timer is started. In periodic mode the count reads L again after that tick.
- R4: In one-shot mode (control bit 30 = 0), a terminal count raises the interrupt, leaves the count at 0 on later ticks, and clears control bit 31.
- R5: The control register is at word address 0: bit 31 enable, bit 30 periodic, bits 28:0 load value, all read back as written. The status register is at word address 1: bits 28:0 hold the live count, which writes cannot change, and bit 30 holds the pending flag.
- R6: A pending interrupt clears only when a write of 1 to status bit 30 is followed by a read of the control register. Either access alone leaves it pending.
- R7: A terminal count that occurs while the interrupt is still pending drives `wdog_rst_o` high for exactly one cycle.
- R8: Once the watchdog has pulsed, further unserviced expiries produce no further pulse until a control write with bit 31 = 0. After such a write the watchdog can fire again.
- R9: A control write with bit 31 = 1 restarts the count from the new load value and clears the pending flag and any armed acknowledge.
- R10: A control write with bit 31 = 0 stops counting, and later ticks leave the count unchanged. The same write clears the pending flag.
- R11: `irq_o` equals status bit 30 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address (0 control, 1 status) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| tick_i | input | 1 | 1 MHz count enable, one cycle wide |
| irq_o | output | 1 | Pending interrupt |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The hardest state to reach is the second expiry with the first still unserviced. It needs exactly 2·(L+1) ticks with no completed acknowledge in between. A partial acknowledge (only the clear write, or only the control read) must not count as service. The bench sweeps small load values in both modes and runs one tick at a time. At each step it compares the live count with L−k. It drives serviced, half-serviced and unserviced periods, then disables and re-enables to show that the tripped state re-arms.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CNT_W    = 29;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned MODE_BIT = 30;
  localparam int unsigned CLR_BIT  = 30;
  localparam logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_READ,
    ACC_WRITE
  } acc_e;
endpackage

// File: rtl/pwt_regs.sv
module pwt_regs
  import pwt_pkg::*;
#(
  parameter int unsigned CNT_W  = pwt_pkg::CNT_W,
  parameter int unsigned ADDR_W = pwt_pkg::ADDR_W,
  parameter int unsigned DATA_W = pwt_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              pending_i,
  input  logic              oneshot_done_i,
  output logic              en_o,
  output logic              periodic_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              restart_o,
  output logic              stop_o,
  output logic              clr_wr_o,
  output logic              trig_rd_o
);
  acc_e acc;
  logic trig_sel, stat_sel, trig_wr;
  logic unused_wdata;

  assign acc      = !req_i ? ACC_IDLE : (we_i ? ACC_WRITE : ACC_READ);
  assign trig_sel = (addr_i == ADDR_W'(TRIG_ADDR));
  assign stat_sel = (addr_i == ADDR_W'(STAT_ADDR));

  assign trig_wr   = (acc == ACC_WRITE) && trig_sel;
  assign restart_o = trig_wr && wdata_i[EN_BIT];
  assign stop_o    = trig_wr && !wdata_i[EN_BIT];
  assign clr_wr_o  = (acc == ACC_WRITE) && stat_sel && wdata_i[CLR_BIT];
  assign trig_rd_o = (acc == ACC_READ) && trig_sel;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      periodic_o <= 1'b0;
      load_o     <= '0;
    end else if (trig_wr) begin
      en_o       <= wdata_i[EN_BIT];
      periodic_o <= wdata_i[MODE_BIT];
      load_o     <= wdata_i[CNT_W-1:0];
    end else if (oneshot_done_i) begin
      en_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (trig_sel) begin
      rdata_o[EN_BIT]    = en_o;
      rdata_o[MODE_BIT]  = periodic_o;
      rdata_o[CNT_W-1:0] = load_o;
    end else if (stat_sel) begin
      rdata_o[CLR_BIT]   = pending_i;
      rdata_o[CNT_W-1:0] = count_i;
    end
  end

  // R5
  trig_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_wr |=> (load_o == $past(wdata_i[CNT_W-1:0])) && (periodic_o == $past(wdata_i[MODE_BIT])));

  // R4
  oneshot_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oneshot_done_i && !trig_wr) |=> !en_o);
endmodule

// File: rtl/pwt_counter.sv
module pwt_counter #(
  parameter int unsigned CNT_W = pwt_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] restart_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o,
  output logic             oneshot_done_o
);
  logic at_zero, step;

  assign at_zero        = (count_o == '0);
  assign step           = en_i && tick_i && !restart_i;
  assign expire_o       = step && at_zero;
  assign oneshot_done_o = expire_o && !periodic_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
    end else if (restart_i) begin
      count_o <= restart_val_i;
    end else if (step) begin
      if (!at_zero)        count_o <= count_o - 1'b1;
      else if (periodic_i) count_o <= load_i;
    end
  end

  // R2
  dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !restart_i && !at_zero) |=> (count_o == $past(count_o) - 1'b1));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(count_o));

  // R3
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && periodic_i) |=> (count_o == $past(load_i)));

  // R4
  oneshot_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oneshot_done_o |=> (count_o == '0));
endmodule

// File: rtl/pwt_service.sv
module pwt_service (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_wr_i,
  input  logic trig_rd_i,
  input  logic restart_i,
  input  logic stop_i,
  output logic pending_o,
  output logic wdog_o
);
  logic armed_q, tripped_q, fire, ack;

  assign fire = expire_i && pending_o && !tripped_q;
  assign ack  = armed_q && trig_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= 1'b0;
      armed_q   <= 1'b0;
      tripped_q <= 1'b0;
      wdog_o    <= 1'b0;
    end else if (stop_i) begin
      pending_o <= 1'b0;
      armed_q   <= 1'b0;
      tripped_q <= 1'b0;
      wdog_o    <= 1'b0;
    end else if (restart_i) begin
      pending_o <= 1'b0;
      armed_q   <= 1'b0;
      wdog_o    <= 1'b0;
    end else begin
      wdog_o <= fire;
      if (fire) tripped_q <= 1'b1;
      // a fresh expiry outranks a completing acknowledge
      if (expire_i)  pending_o <= 1'b1;
      else if (ack)  pending_o <= 1'b0;
      if (clr_wr_i)       armed_q <= 1'b1;
      else if (trig_rd_i) armed_q <= 1'b0;
    end
  end

  // R6
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !ack && !restart_i && !stop_i) |=> pending_o);

  // R7
  fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && pending_o && !tripped_q && !restart_i && !stop_i) |=> wdog_o);

  // R7
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_o |=> !wdog_o);

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tripped_q && !stop_i) |=> !wdog_o);
endmodule

// File: rtl/periodic_wdog_timer.sv
module periodic_wdog_timer
  import pwt_pkg::*;
#(
  parameter int unsigned CNT_W  = pwt_pkg::CNT_W,
  parameter int unsigned ADDR_W = pwt_pkg::ADDR_W,
  parameter int unsigned DATA_W = pwt_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  output logic              irq_o,
  output logic              wdog_rst_o
);
  logic [CNT_W-1:0] count, load;
  logic en, periodic, restart, stop, clr_wr, trig_rd;
  logic expire, oneshot_done, pending;

  pwt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .count_i(count), .pending_i(pending), .oneshot_done_i(oneshot_done),
    .en_o(en), .periodic_o(periodic), .load_o(load),
    .restart_o(restart), .stop_o(stop), .clr_wr_o(clr_wr), .trig_rd_o(trig_rd)
  );

  pwt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .en_i(en), .periodic_i(periodic), .load_i(load),
    .restart_i(restart), .restart_val_i(wdata_i[CNT_W-1:0]),
    .count_o(count), .expire_o(expire), .oneshot_done_o(oneshot_done)
  );

  pwt_service u_svc (
    .clk_i, .rst_ni,
    .expire_i(expire), .clr_wr_i(clr_wr), .trig_rd_i(trig_rd),
    .restart_i(restart), .stop_i(stop),
    .pending_o(pending), .wdog_o(wdog_rst_o)
  );

  assign irq_o = pending;

  // R11
  irq_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(STAT_ADDR)) |-> (rdata_o[CLR_BIT] == irq_o));
endmodule

// File: tb/tb_periodic_wdog_timer.sv
module tb_periodic_wdog_timer;
  localparam int CLK_P = 10;
  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] PER = 32'h4000_0000;
  localparam logic [31:0] CLR = 32'h4000_0000;
  localparam logic [31:0] CNT_M = 32'h1FFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, wdog;
  int checks = 0, errors = 0, wdog_cnt = 0;

  periodic_wdog_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .irq_o(irq), .wdog_rst_o(wdog)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) if (wdog) wdog_cnt++;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = 2'(a); wdata = d;
    @(negedge clk); req = 0; we = 0; #1;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = 2'(a);
    #1 d = rdata;
    @(negedge clk); req = 0; #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0; #1;
    end
  endtask

  function automatic int cnt_of(input logic [31:0] s); return int'(s & CNT_M); endfunction

  initial begin
    logic [31:0] d;
    int w0;
    repeat (3) @(negedge clk);
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 stat", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wdog", {31'b0, wdog}, 0);
    rst_n = 1'b1;

    // periodic sweep
    for (int L = 0; L <= 5; L++) begin
      wr(0, 0); wr(1, 0);
      wr(0, EN | PER | 32'(L));
      rd(0, d); chk("R5 readback", d, EN | PER | 32'(L));
      rd(1, d); chk("R9 start count", 32'(cnt_of(d)), 32'(L));
      repeat (3) @(negedge clk);
      rd(1, d); chk("R2 hold no tick", 32'(cnt_of(d)), 32'(L));
      for (int k = 1; k <= L; k++) begin
        ticks(1);
        rd(1, d); chk("R2 decrement", 32'(cnt_of(d)), 32'(L - k));
        chk("R3 no early irq", {31'b0, irq}, 0);
      end
      w0 = wdog_cnt;
      ticks(1);
      chk("R3 irq at L+1", {31'b0, irq}, 1);
      rd(1, d); chk("R3 reload", 32'(cnt_of(d)), 32'(L));
      chk("R11 irq mirrors bit30", {31'b0, d[30]}, {31'b0, irq});
      rd(0, d); chk("R6 read alone", {31'b0, irq}, 1);
      wr(1, CLR); chk("R6 clear alone", {31'b0, irq}, 1);
      rd(0, d); chk("R6 full ack", {31'b0, irq}, 0);
      ticks(L + 1);
      chk("R3 second period irq", {31'b0, irq}, 1);
      chk("R7 no fire after service", 32'(wdog_cnt), 32'(w0));
      // half service: clear write only, then expire again
      wr(1, CLR);
      ticks(L + 1);
      chk("R7 fire on 2nd miss", 32'(wdog_cnt), 32'(w0 + 1));
      ticks(2 * (L + 1));
      chk("R8 sticky", 32'(wdog_cnt), 32'(w0 + 1));
      wr(0, 32'(L));
      chk("R10 irq cleared", {31'b0, irq}, 0);
      rd(1, d); w0 = cnt_of(d);
      ticks(2);
      rd(1, d); chk("R10 stopped", 32'(cnt_of(d)), 32'(w0));
      w0 = wdog_cnt;
      wr(0, EN | PER | 32'(L));
      ticks(2 * (L + 1));
      chk("R8 rearm after disable", 32'(wdog_cnt), 32'(w0 + 1));
    end

    // one-shot sweep
    for (int L = 0; L <= 3; L++) begin
      wr(0, 0); wr(1, 0);
      wr(0, EN | 32'(L));
      ticks(L);
      chk("R4 no early irq", {31'b0, irq}, 0);
      ticks(1);
      chk("R4 irq", {31'b0, irq}, 1);
      rd(0, d); chk("R4 enable cleared", d, 32'(L));
      ticks(3);
      rd(1, d); chk("R4 count stays 0", 32'(cnt_of(d)), 0);
    end

    // restart clears tracking
    wr(0, 0); wr(1, 0);
    wr(0, EN | PER | 32'd3);
    ticks(4);
    chk("R9 pending before restart", {31'b0, irq}, 1);
    wr(1, CLR);
    w0 = wdog_cnt;
    wr(0, EN | PER | 32'd5);
    chk("R9 pending cleared", {31'b0, irq}, 0);
    rd(1, d); chk("R9 new load", 32'(cnt_of(d)), 5);
    rd(0, d);
    chk("R9 armed ack discarded", {31'b0, irq}, 0);
    ticks(6);
    chk("R9 expiry after restart", {31'b0, irq}, 1);
    rd(0, d);
    chk("R9 stale clear not applied", {31'b0, irq}, 1);
    chk("R9 no fire", 32'(wdog_cnt), 32'(w0));

    // status count is read-only
    ticks(2);
    rd(1, d); w0 = cnt_of(d);
    wr(1, CNT_M);
    rd(1, d); chk("R5 count read-only", 32'(cnt_of(d)), 32'(w0));
    chk("R5 pending kept", {31'b0, d[30]}, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule